// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a physical address. It does this by reading a three-level page table held in a memory of 64-bit words. A requester presents an address with a valid/ready handshake. The walker samples the translation control word and the current privilege level at that moment. It then either passes the address straight through or walks the table with one memory read per level. The answer is a 64-bit physical address or a page-fault flag, and it is held until the requester acknowledges it.

Table entries can end the walk at any level. A hit at the top or middle level maps a large page: the virtual page-number fields below that level are copied into the physical address. The memory side is a simple read port with one read outstanding at a time. A read is issued with valid/ready and the entry returns some cycles later with a response strobe.

Top module: `vaddr_walker`

## Requirements
- R1: A synchronous reset leaves the walker idle: `req_ready`=1, `rsp_valid`=0, `rsp_fault`=0 and `mem_rd_valid`=0. This holds even when the reset arrives in the middle of a walk.
- R2: A request is bypassed when bit 63 of `xlat_ctrl` is 0. The response then appears in the cycle after acceptance with `rsp_paddr` equal to the full 64-bit `req_vaddr` and `rsp_fault`=0, and no memory read is issued.
- R3: A request is also bypassed when `priv_mode` is 2'b11 (machine level), whatever bit 63 of `xlat_ctrl` holds. The result is the same as in R2.
- R4: A walk starts at the top level and goes down. Each read asks for the word index (table_base*4096 + vpn*8)/8. The first table base is `xlat_ctrl[43:0]`, and each later base is bits 53:10 of the entry just read. The vpn at the top, middle and bottom levels is vaddr[38:30], [29:21] and [20:12].
- R5: An entry with bit 0 (valid) set is a leaf when bit 1 or bit 3 is set. A leaf at the bottom level gives {entry[53:10], vaddr[11:0]}.
- R6: A leaf at the middle level gives {entry[53:19], vaddr[20:0]} and ends the walk after two reads.
- R7: A leaf at the top level gives {entry[53:28], vaddr[29:0]} and ends the walk after one read.
- R8: An entry with bit 0 clear ends the walk with `rsp_fault`=1 and `rsp_paddr`=0, at whatever level it is read.
- R9: A valid non-leaf entry at the bottom level ends the walk with `rsp_fault`=1 and `rsp_paddr`=0 after three reads.
- R10: Once raised, `rsp_valid`, `rsp_paddr` and `rsp_fault` stay unchanged until a cycle with `rsp_ack`=1. The walker then returns to idle. `req_ready` is 0 from acceptance until that acknowledge.
- R11: `mem_rd_valid` and `mem_rd_index` are held unchanged until `mem_rd_ready`. No new read is issued while one is outstanding.
- R12: A walked physical address always has bits 63:56 zero, whatever entry bits 63:54 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 64 | Virtual address; bits 38:0 are used for walking |
| xlat_ctrl | input | 64 | Translation control word: bit 63 enables, bits 43:0 give the root table page number |
| priv_mode | input | 2 | Current privilege level, 2'b11 = machine |
| rsp_valid | output | 1 | Result present |
| rsp_paddr | output | 64 | Physical address, or 0 on a fault |
| rsp_fault | output | 1 | Page fault |
| rsp_ack | input | 1 | Requester consumes the result |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_index | output | 53 | 64-bit word index of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Page table entry |

## Verification
The bench holds three tables in a small word array. It sweeps every mix of the vpn field values 0, 1, 170, 256 and 511 at each level, and ends the walk at each of the three levels. This separates the three ways of building the address and catches a field taken from the wrong place. The leaf flag cycles through R-only, X-only and both, and entry bits 63:54 are filled with junk. The memory port sees varying ready stalls and response delays, which tests that a read is held steady. Each privilege and enable combination that should bypass the walk is tried. Invalid entries at each level, a bottom-level pointer and a reset during a walk exercise the fault and recovery paths.

// File: rtl/walk_pkg.sv
package walk_pkg;
    // address geometry of the three-level scheme
    parameter int unsigned XLEN_W   = 64;
    parameter int unsigned VA_W     = 39;
    parameter int unsigned PA_W     = 56;
    parameter int unsigned OFF_W    = 12;
    parameter int unsigned VPN_W    = 9;
    parameter int unsigned LEVELS   = 3;
    parameter int unsigned PTE_W    = 64;
    parameter int unsigned PPN_LSB  = 10;
    // entry flag positions
    parameter int unsigned FLAG_V   = 0;
    parameter int unsigned FLAG_R   = 1;
    parameter int unsigned FLAG_X   = 3;
    // control word
    parameter int unsigned CTRL_EN_BIT = 63;
    parameter logic [1:0]  PRIV_MACHINE = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAULT = 3'd4
    } walk_state_e;
endpackage

// File: rtl/walk_index_gen.sv
module walk_index_gen #(
    parameter int unsigned VA_W   = walk_pkg::VA_W,
    parameter int unsigned PA_W   = walk_pkg::PA_W,
    parameter int unsigned OFF_W  = walk_pkg::OFF_W,
    parameter int unsigned VPN_W  = walk_pkg::VPN_W,
    parameter int unsigned LEVELS = walk_pkg::LEVELS,
    parameter int unsigned PTE_W  = walk_pkg::PTE_W,
    localparam int unsigned PPN_W = PA_W - OFF_W,
    localparam int unsigned LVL_W = $clog2(LEVELS),
    localparam int unsigned ENT_SH = $clog2(PTE_W / 8),
    localparam int unsigned IDX_W = PA_W - ENT_SH
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    input  logic [PPN_W-1:0] base_ppn,
    output logic [IDX_W-1:0] word_idx
);
    logic [VPN_W-1:0] vpn_arr [LEVELS];
    logic [VPN_W-1:0] vpn_sel;
    logic [PA_W-1:0]  byte_addr;
    logic [ENT_SH-1:0] unused_low;

    for (genvar g = 0; g < LEVELS; g++) begin : g_vpn
        assign vpn_arr[g] = vaddr[OFF_W + g*VPN_W +: VPN_W];
    end

    always_comb begin
        vpn_sel = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (level == LVL_W'(l)) vpn_sel = vpn_arr[l];
        end
    end

    assign byte_addr  = {base_ppn, {OFF_W{1'b0}}} + (PA_W'(vpn_sel) << ENT_SH);
    assign word_idx   = byte_addr[PA_W-1:ENT_SH];
    assign unused_low = byte_addr[ENT_SH-1:0];
endmodule

// File: rtl/walk_pte_decode.sv
module walk_pte_decode #(
    parameter int unsigned PTE_W   = walk_pkg::PTE_W,
    parameter int unsigned PA_W    = walk_pkg::PA_W,
    parameter int unsigned OFF_W   = walk_pkg::OFF_W,
    parameter int unsigned PPN_LSB = walk_pkg::PPN_LSB,
    localparam int unsigned PPN_W  = PA_W - OFF_W
) (
    input  logic [PTE_W-1:0] pte,
    output logic             is_valid,
    output logic             is_leaf,
    output logic [PPN_W-1:0] ppn
);
    logic unused_bits;

    assign is_valid    = pte[walk_pkg::FLAG_V];
    assign is_leaf     = pte[walk_pkg::FLAG_R] | pte[walk_pkg::FLAG_X];
    assign ppn         = pte[PPN_LSB +: PPN_W];
    assign unused_bits = ^{pte[PTE_W-1:PPN_LSB+PPN_W], pte[PPN_LSB-1:4], pte[2]};
endmodule

// File: rtl/walk_leaf_compose.sv
module walk_leaf_compose #(
    parameter int unsigned XLEN_W = walk_pkg::XLEN_W,
    parameter int unsigned VA_W   = walk_pkg::VA_W,
    parameter int unsigned PA_W   = walk_pkg::PA_W,
    parameter int unsigned OFF_W  = walk_pkg::OFF_W,
    parameter int unsigned VPN_W  = walk_pkg::VPN_W,
    parameter int unsigned LEVELS = walk_pkg::LEVELS,
    localparam int unsigned PPN_W = PA_W - OFF_W,
    localparam int unsigned LVL_W = $clog2(LEVELS),
    localparam int unsigned TOP_KEEP = OFF_W + (LEVELS-1)*VPN_W
) (
    input  logic [PPN_W-1:0]  leaf_ppn,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [LVL_W-1:0]  level,
    output logic [XLEN_W-1:0] paddr
);
    logic [PA_W-1:0] frame;
    logic [PA_W-1:0] pa_lvl [LEVELS];
    logic [PA_W-1:0] pa_sel;
    logic unused_va;

    assign frame = {leaf_ppn, {OFF_W{1'b0}}};

    // a leaf at level g keeps the low OFF_W + g*VPN_W bits of the virtual address
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        localparam int unsigned KEEP = OFF_W + g*VPN_W;
        assign pa_lvl[g] = {frame[PA_W-1:KEEP], vaddr[KEEP-1:0]};
    end

    always_comb begin
        pa_sel = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (level == LVL_W'(l)) pa_sel = pa_lvl[l];
        end
    end

    assign paddr     = XLEN_W'(pa_sel);
    assign unused_va = ^vaddr[VA_W-1:TOP_KEEP];
endmodule

// File: rtl/vaddr_walker.sv
module vaddr_walker #(
    parameter int unsigned XLEN_W = walk_pkg::XLEN_W,
    parameter int unsigned VA_W   = walk_pkg::VA_W,
    parameter int unsigned PA_W   = walk_pkg::PA_W,
    parameter int unsigned OFF_W  = walk_pkg::OFF_W,
    parameter int unsigned VPN_W  = walk_pkg::VPN_W,
    parameter int unsigned LEVELS = walk_pkg::LEVELS,
    parameter int unsigned PTE_W  = walk_pkg::PTE_W,
    localparam int unsigned PPN_W = PA_W - OFF_W,
    localparam int unsigned LVL_W = $clog2(LEVELS),
    localparam int unsigned IDX_W = PA_W - $clog2(PTE_W / 8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [XLEN_W-1:0] req_vaddr,
    input  logic [XLEN_W-1:0] xlat_ctrl,
    input  logic [1:0]        priv_mode,
    output logic              rsp_valid,
    output logic [XLEN_W-1:0] rsp_paddr,
    output logic              rsp_fault,
    input  logic              rsp_ack,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [IDX_W-1:0]  mem_rd_index,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data
);
    import walk_pkg::*;

    typedef struct packed {
        walk_state_e       st;
        logic [VA_W-1:0]   va;
        logic [PPN_W-1:0]  base;
        logic [LVL_W-1:0]  lvl;
        logic [XLEN_W-1:0] pa;
    } walk_regs_t;

    walk_regs_t regs_d, regs_q;

    logic              bypass;
    logic              pte_valid, pte_leaf;
    logic [PPN_W-1:0]  pte_ppn;
    logic [XLEN_W-1:0] leaf_pa;
    logic              unused_ctrl;

    assign bypass      = !xlat_ctrl[CTRL_EN_BIT] || (priv_mode == PRIV_MACHINE);
    assign unused_ctrl = ^xlat_ctrl[XLEN_W-2:PPN_W];

    walk_index_gen #(
        .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .VPN_W(VPN_W),
        .LEVELS(LEVELS), .PTE_W(PTE_W)
    ) u_index (
        .vaddr   (regs_q.va),
        .level   (regs_q.lvl),
        .base_ppn(regs_q.base),
        .word_idx(mem_rd_index)
    );

    walk_pte_decode #(
        .PTE_W(PTE_W), .PA_W(PA_W), .OFF_W(OFF_W)
    ) u_decode (
        .pte     (mem_rsp_data),
        .is_valid(pte_valid),
        .is_leaf (pte_leaf),
        .ppn     (pte_ppn)
    );

    walk_leaf_compose #(
        .XLEN_W(XLEN_W), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W),
        .VPN_W(VPN_W), .LEVELS(LEVELS)
    ) u_compose (
        .leaf_ppn(pte_ppn),
        .vaddr   (regs_q.va),
        .level   (regs_q.lvl),
        .paddr   (leaf_pa)
    );

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (bypass) begin
                        regs_d.pa = req_vaddr;
                        regs_d.st = ST_DONE;
                    end else begin
                        regs_d.va   = req_vaddr[VA_W-1:0];
                        regs_d.base = xlat_ctrl[PPN_W-1:0];
                        regs_d.lvl  = LVL_W'(LEVELS - 1);
                        regs_d.pa   = '0;
                        regs_d.st   = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (mem_rd_ready) regs_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!pte_valid) begin
                        regs_d.pa = '0;
                        regs_d.st = ST_FAULT;
                    end else if (pte_leaf) begin
                        regs_d.pa = leaf_pa;
                        regs_d.st = ST_DONE;
                    end else if (regs_q.lvl == '0) begin
                        regs_d.pa = '0;
                        regs_d.st = ST_FAULT;
                    end else begin
                        regs_d.base = pte_ppn;
                        regs_d.lvl  = regs_q.lvl - 1'b1;
                        regs_d.st   = ST_ISSUE;
                    end
                end
            end
            ST_DONE, ST_FAULT: begin
                if (rsp_ack) regs_d.st = ST_IDLE;
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.st   <= ST_IDLE;
            regs_q.va   <= '0;
            regs_q.base <= '0;
            regs_q.lvl  <= '0;
            regs_q.pa   <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign req_ready    = (regs_q.st == ST_IDLE);
    assign rsp_valid    = (regs_q.st == ST_DONE) || (regs_q.st == ST_FAULT);
    assign rsp_fault    = (regs_q.st == ST_FAULT);
    assign rsp_paddr    = regs_q.pa;
    assign mem_rd_valid = (regs_q.st == ST_ISSUE);

    // R2
    bypass_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !xlat_ctrl[CTRL_EN_BIT])
        |=> (rsp_valid && !rsp_fault && rsp_paddr == $past(req_vaddr)));

    // R3
    machine_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && priv_mode == PRIV_MACHINE)
        |=> (rsp_valid && !rsp_fault && rsp_paddr == $past(req_vaddr)));

    // R8
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ack)
        |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || mem_rd_valid) |-> !req_ready);

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready)
        |=> (mem_rd_valid && $stable(mem_rd_index)));

    // R11
    rd_single_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);
endmodule

// File: tb/tb_vaddr_walker.sv
`timescale 1ns/1ps
module tb_vaddr_walker;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready;
    logic [63:0] req_vaddr, xlat_ctrl;
    logic [1:0]  priv_mode;
    logic        rsp_valid, rsp_fault, rsp_ack;
    logic [63:0] rsp_paddr;
    logic        mem_rd_valid, mem_rd_ready;
    logic [52:0] mem_rd_index;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;

    always #4 clk = ~clk;

    vaddr_walker dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .xlat_ctrl(xlat_ctrl), .priv_mode(priv_mode),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_ack(rsp_ack),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_index(mem_rd_index),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // table memory: page 1 = root, page 2 = middle, page 3 = bottom
    logic [63:0] mem [4096];
    int  cfg_stall = 0, cfg_lat = 0;
    bit  block_rd = 0;
    int  nread = 0;
    logic [52:0] idx_log [8];
    bit  hold_bad = 0;

    // memory model, updated away from the active edge
    bit  pend = 0, seen = 0;
    int  wait_left = 0, lat_left = 0;
    logic [52:0] pidx, held;
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (rst) begin
            pend = 0; seen = 0; wait_left = 0; mem_rd_ready = 1'b0;
        end else if (pend) begin
            mem_rd_ready = 1'b0;
            if (lat_left == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem[pidx[11:0]];
                pend = 0;
            end else lat_left--;
        end else if (mem_rd_valid) begin
            if (!seen) begin seen = 1; held = mem_rd_index; end
            else if (mem_rd_index !== held) hold_bad = 1;
            if (wait_left == 0 && !block_rd) begin
                mem_rd_ready = 1'b1;
                pend = 1; pidx = mem_rd_index; lat_left = cfg_lat;
                idx_log[nread % 8] = mem_rd_index;
                nread++;
                seen = 0; wait_left = cfg_stall;
            end else begin
                mem_rd_ready = 1'b0;
                if (wait_left > 0) wait_left--;
            end
        end else begin
            mem_rd_ready = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ptr_pte(input logic [43:0] p);
        return {10'h000, p, 2'b00, 8'h01};
    endfunction

    function automatic logic [63:0] leaf_pte(input logic [43:0] p, input int fsel);
        logic [7:0] f;
        f = (fsel == 0) ? 8'hC3 : (fsel == 1) ? 8'hC9 : 8'hCB;
        return {10'h2AB, p, 2'b10, f};
    endfunction

    // send one request, wait for its answer, check hold and acknowledge
    task automatic do_req(input logic [63:0] va, input logic [63:0] ctrl, input logic [1:0] pv,
                          output logic [63:0] pa, output logic flt, output int lat);
        bit busy_ok = 1;
        @(negedge clk);
        req_vaddr = va; xlat_ctrl = ctrl; priv_mode = pv; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R10 ready when idle", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 300) begin
            if (req_ready) busy_ok = 0;
            @(negedge clk);
            lat++;
        end
        if (req_ready) busy_ok = 0;
        chk(busy_ok, "R10 ready low while busy", 64'(busy_ok), 64'd1);
        pa = rsp_paddr; flt = rsp_fault;
        @(negedge clk);
        chk(rsp_valid && rsp_paddr == pa && rsp_fault == flt, "R10 result held",
            rsp_paddr, pa);
        rsp_ack = 1'b1;
        @(negedge clk);
        rsp_ack = 1'b0;
        chk(!rsp_valid && req_ready, "R10 idle after ack", 64'(rsp_valid), 64'd0);
    endtask

    // kind = level of the leaf (2 top, 1 middle, 0 bottom)
    task automatic walk_case(input int v2, input int v1, input int v0, input int kind, input int fsel,
                             input logic [24:0] hi);
        logic [43:0] lp;
        logic [63:0] va, pa, exp_pa;
        logic [52:0] exp_idx [3];
        logic flt;
        int lat, n0, nexp;
        lp = 44'hC3A_5F0E_1B20 + {17'd0, 9'(v2), 9'(v1), 9'(v0)};
        va = {hi, 9'(v2), 9'(v1), 9'(v0), 12'(12'hA5C ^ 12'(v2 + v1 * 3 + v0 * 7))};
        exp_idx[0] = {44'd1, 9'(v2)};
        exp_idx[1] = {44'd2, 9'(v1)};
        exp_idx[2] = {44'd3, 9'(v0)};
        if (kind == 2) begin
            mem[512 + v2] = leaf_pte(lp, fsel);
            exp_pa = {8'h00, lp[43:18], va[29:0]};
        end else if (kind == 1) begin
            mem[512 + v2]  = ptr_pte(44'd2);
            mem[1024 + v1] = leaf_pte(lp, fsel);
            exp_pa = {8'h00, lp[43:9], va[20:0]};
        end else begin
            mem[512 + v2]  = ptr_pte(44'd2);
            mem[1024 + v1] = ptr_pte(44'd3);
            mem[1536 + v0] = leaf_pte(lp, fsel);
            exp_pa = {8'h00, lp, va[11:0]};
        end
        nexp = 3 - kind;
        n0 = nread;
        do_req(va, {1'b1, 19'h5A5A5, 44'd1}, (v0 % 2 == 0) ? 2'b00 : 2'b01, pa, flt, lat);
        chk(nread - n0 == nexp, "R4 read count", 64'(nread - n0), 64'(nexp));
        for (int k = 0; k < nexp; k++)
            chk(idx_log[(n0 + k) % 8] == exp_idx[k], "R4 entry index",
                64'(idx_log[(n0 + k) % 8]), 64'(exp_idx[k]));
        chk(!flt, "R5 no fault on leaf", 64'(flt), 64'd0);
        if (kind == 2)      chk(pa == exp_pa, "R7 top-level leaf address", pa, exp_pa);
        else if (kind == 1) chk(pa == exp_pa, "R6 middle-level leaf address", pa, exp_pa);
        else                chk(pa == exp_pa, "R5 bottom-level leaf address", pa, exp_pa);
        chk(pa[63:56] == 8'h00, "R12 upper bits zero", 64'(pa[63:56]), 64'd0);
    endtask

    task automatic fault_case(input int stop_lvl, input bit bottom_ptr, input string req);
        logic [63:0] pa;
        logic flt;
        int lat, n0, nexp;
        mem[512 + 3]  = (stop_lvl == 2) ? 64'h0000_0000_0000_000A : ptr_pte(44'd2);
        mem[1024 + 4] = (stop_lvl == 1) ? 64'h0000_0000_0000_000A : ptr_pte(44'd3);
        mem[1536 + 5] = bottom_ptr ? ptr_pte(44'd5) : 64'h0000_0000_0000_000A;
        nexp = 3 - stop_lvl;
        n0 = nread;
        do_req({25'd0, 9'd3, 9'd4, 9'd5, 12'h123}, {1'b1, 19'd0, 44'd1}, 2'b01, pa, flt, lat);
        chk(flt == 1'b1, req, 64'(flt), 64'd1);
        chk(pa == 64'd0, req, pa, 64'd0);
        chk(nread - n0 == nexp, req, 64'(nread - n0), 64'(nexp));
    endtask

    initial begin
        logic [63:0] pa;
        logic flt;
        int lat, n0;
        int vs [5] = '{0, 1, 170, 256, 511};
        int cnt = 0;
        for (int i = 0; i < 4096; i++) mem[i] = 64'd0;
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; xlat_ctrl = '0;
        priv_mode = 2'b00; rsp_ack = 1'b0;
        mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
        chk(rsp_fault == 1'b0, "R1 no fault after reset", 64'(rsp_fault), 64'd0);
        chk(mem_rd_valid == 1'b0, "R1 no read after reset", 64'(mem_rd_valid), 64'd0);

        // bypass cases: disabled at each privilege, and machine level with enable set
        for (int m = 0; m < 5; m++) begin
            logic [63:0] va;
            logic [63:0] ctl;
            logic [1:0]  pv;
            va  = 64'hFEDC_BA98_7654_3210 ^ 64'(m * 64'h1111);
            ctl = (m < 4) ? {1'b0, 63'h1234_5678} : {1'b1, 63'd1};
            pv  = (m < 4) ? 2'(m) : 2'b11;
            n0 = nread;
            do_req(va, ctl, pv, pa, flt, lat);
            if (m < 4) begin
                chk(pa == va && !flt, "R2 bypass address", pa, va);
                chk(lat == 1, "R2 bypass latency", 64'(lat), 64'd1);
                chk(nread == n0, "R2 no memory read", 64'(nread - n0), 64'd0);
            end else begin
                chk(pa == va && !flt, "R3 machine bypass address", pa, va);
                chk(lat == 1, "R3 machine bypass latency", 64'(lat), 64'd1);
                chk(nread == n0, "R3 no memory read", 64'(nread - n0), 64'd0);
            end
        end

        // sweep of vpn fields and leaf levels, with varying memory timing
        for (int a = 0; a < 5; a++)
            for (int b = 0; b < 5; b++)
                for (int c = 0; c < 5; c++)
                    for (int kind = 0; kind < 3; kind++) begin
                        cfg_stall = cnt % 3;
                        cfg_lat   = (cnt / 3) % 2;
                        walk_case(vs[a], vs[b], vs[c], kind, cnt % 3,
                                  (cnt % 2 == 1) ? 25'h1FF_FFFF : 25'h000_0000);
                        cnt++;
                    end

        // fault paths
        cfg_stall = 1; cfg_lat = 1;
        fault_case(2, 1'b0, "R8 invalid top entry");
        fault_case(1, 1'b0, "R8 invalid middle entry");
        fault_case(0, 1'b0, "R8 invalid bottom entry");
        fault_case(0, 1'b1, "R9 pointer at bottom level");

        chk(hold_bad == 1'b0, "R11 read held until accepted", 64'(hold_bad), 64'd0);

        // reset in the middle of a walk
        block_rd = 1;
        @(negedge clk);
        req_vaddr = 64'h0000_0012_3456_7000; xlat_ctrl = {1'b1, 63'd1};
        priv_mode = 2'b01; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(mem_rd_valid == 1'b1, "R11 read waits while not ready", 64'(mem_rd_valid), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        block_rd = 0;
        @(negedge clk);
        chk(req_ready && !mem_rd_valid && !rsp_valid && !rsp_fault, "R1 reset mid-walk",
            {60'd0, req_ready, mem_rd_valid, rsp_valid, rsp_fault}, 64'h8);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule